// File: doc/BRIEF.md
# Flash Fetch Wait-State Controller

This block sits between a processor's fetch and read port and a slow flash array. It turns each accepted core request into one flash read strobe. It returns the flash data to the core either as soon as the flash answers or one cycle later, depending on a 2-bit read mode held in a small control register.

Two of the modes add branch-target prefetch suppression. A conditional branch-target request from the core is not sent to flash at once. It is parked until the core reports the branch outcome, and then only the path that is actually taken is fetched: the parked target if taken, the sequential address if not. Without suppression the target is fetched speculatively, and a not-taken outcome then costs a second fetch of the sequential address.

The controller keeps at most one flash access in flight. It reports through a busy flag when it can accept a new request, and it counts every flash strobe it issues.

Top module: `fetch_wait_ctrl`

## Requirements
- R1: The mode field reads back on `cfg_rdata[1:0]` and resets to 1. Bit 0 selects one wait state (1) or none (0). Bit 1 enables branch-target suppression. The encodings are 0 = no wait, 1 = one wait, 2 = no wait with suppression, 3 = one wait with suppression.
- R2: `cfg_rdata[31:2]` always reads 0, and writing ones to `cfg_wdata[31:2]` leaves the register unchanged apart from bits 1:0.
- R3: With bit 0 of the mode clear, `core_rvalid` is high in the same cycle as `mem_rvalid`. With bit 0 set, it comes exactly one cycle later, carrying the data the flash returned.
- R4: With suppression on, an accepted request flagged by `core_cbt` causes no `mem_rd` until `res_valid` is seen.
- R5: In the cycle after a resolution of a parked request, `mem_rd` is high and `mem_addr` is the parked target if `res_taken` is 1, or `res_seq_addr` if it is 0. The parked request is otherwise dropped.
- R6: Without suppression, a flagged request is strobed in the cycle after acceptance. A later not-taken resolution adds one strobe to `res_seq_addr`. A not-taken branch therefore costs two strobes without suppression and one with it; a taken branch costs one either way.
- R7: The mode in force for an access is the one sampled at acceptance. A register write during the access affects only later accesses.
- R8: A request is accepted on a clock edge where `core_req` is 1 and `core_busy` is 0. `core_busy` stays high from acceptance until the cycle after the last `core_rvalid` of that access, so only one flash access is ever outstanding.
- R9: `strobe_cnt` resets to 0 and increases by exactly one for each cycle in which `mem_rd` is high.
- R10: `mem_rd` is a single-cycle pulse. For a request that is not parked, it is issued in the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 32 | Control register write data |
| cfg_rdata | output | 32 | Control register read data |
| core_req | input | 1 | Core fetch or read request |
| core_addr | input | 16 | Request address |
| core_cbt | input | 1 | Request is a conditional branch-target prefetch |
| core_busy | output | 1 | Controller cannot accept a request |
| core_rvalid | output | 1 | Read data valid to the core |
| core_rdata | output | 32 | Read data to the core |
| res_valid | input | 1 | Branch resolution strobe |
| res_taken | input | 1 | Branch resolved as taken |
| res_seq_addr | input | 16 | Sequential address of the resolved branch |
| mem_rd | output | 1 | Flash read strobe |
| mem_addr | output | 16 | Flash read address |
| mem_rvalid | input | 1 | Flash data valid |
| mem_rdata | input | 32 | Flash read data |
| strobe_cnt | output | 16 | Count of issued flash strobes |

## Verification
Every one of the four modes is run with a plain request, a taken branch-target request and a not-taken branch-target request. Comparing strobe counts across modes separates suppression from speculation: only a not-taken branch without suppression gives two strobes. Strobe timing relative to the resolution separates parked requests from immediate ones, and data latency separates the zero-wait modes from the one-wait modes. Directed cases cover a mode change in the middle of an access and a request held high back to back, which shows that the busy window really blocks a second access.

// File: rtl/fwc_pkg.sv
// Shared types for the flash fetch wait-state controller.
// Assumes the mode field is 2 bits: bit 0 = wait state, bit 1 = suppression.
package fwc_pkg;
    localparam int MODE_W = 2;

    typedef enum logic [MODE_W-1:0] {
        MODE_WS0     = 2'd0,
        MODE_WS1     = 2'd1,
        MODE_WS0_SUP = 2'd2,
        MODE_WS1_SUP = 2'd3
    } rd_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_HOLD  = 3'd1,
        ST_ISSUE = 3'd2,
        ST_WAIT  = 3'd3,
        ST_DLV   = 3'd4
    } fsm_e;

    function automatic logic mode_wait(input rd_mode_e m);
        return m[0];
    endfunction

    function automatic logic mode_sup(input rd_mode_e m);
        return m[1];
    endfunction
endpackage

// File: rtl/fwc_mode_reg.sv
// Control register holding the read mode.
// Only the low MODE_W bits are stored; the reserved bits read as zero and
// writes to them are dropped. Resets to one wait state without suppression.
module fwc_mode_reg
    import fwc_pkg::*;
#(
    parameter int REG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    output rd_mode_e         mode
);
    localparam int RSV_W = REG_W - MODE_W;

    logic rsv_written;
    assign rsv_written = |wdata[REG_W-1:MODE_W];

    // Capture the mode field on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) mode <= MODE_WS1;
        else if (we) mode <= rd_mode_e'(wdata[MODE_W-1:0]);
    end

    assign rdata = {{RSV_W{1'b0}}, mode};

    a_r1_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> rdata[MODE_W-1:0] == $past(wdata[MODE_W-1:0]));
    a_r2_rsv_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (we && rsv_written) |=> rdata[REG_W-1:MODE_W] == '0);
endmodule

// File: rtl/fwc_strobe_cnt.sv
// Counter of flash read strobes.
// Wraps at 2**CW; a strobe is one cycle with strobe high.
module fwc_strobe_cnt #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          strobe,
    output logic [CW-1:0] count
);
    // Advance once per strobe cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) count <= '0;
        else if (strobe) count <= count + 1'b1;
    end

    a_r9_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> count == $past(count) + 1'b1);
    a_r9_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> $stable(count));
endmodule

// File: rtl/fwc_seq.sv
// Access sequencer: accepts one core request at a time, parks branch-target
// prefetches when suppression is on, issues a one-cycle flash strobe, and
// returns data with zero or one added wait state.
// Assumes the flash raises mem_rvalid once per strobe, some cycles later,
// and that res_valid refers to the most recent branch-target request.
module fwc_seq
    import fwc_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  rd_mode_e      mode_i,
    input  logic          core_req,
    input  logic [AW-1:0] core_addr,
    input  logic          core_cbt,
    output logic          core_busy,
    output logic          core_rvalid,
    output logic [DW-1:0] core_rdata,
    input  logic          res_valid,
    input  logic          res_taken,
    input  logic [AW-1:0] res_seq_addr,
    output logic          mem_rd,
    output logic [AW-1:0] mem_addr,
    input  logic          mem_rvalid,
    input  logic [DW-1:0] mem_rdata
);
    fsm_e          state;
    rd_mode_e      acc_mode;
    logic [AW-1:0] tgt_addr;
    logic [AW-1:0] iss_addr;
    logic [DW-1:0] dlv_data;
    logic          seq_pend;
    logic [AW-1:0] pend_addr;

    logic accept, park_now, res_for_held, pend_set, pend_take;

    assign accept       = (state == ST_IDLE) && !seq_pend && core_req;
    assign park_now     = accept && core_cbt && mode_sup(mode_i);
    assign res_for_held = (state == ST_HOLD) || park_now;
    assign pend_set     = res_valid && !res_taken && !res_for_held;
    assign pend_take    = (state == ST_IDLE) && seq_pend;

    // Main access state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            acc_mode <= MODE_WS1;
            tgt_addr <= '0;
            iss_addr <= '0;
            dlv_data <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (pend_take) begin
                        state    <= ST_ISSUE;
                        iss_addr <= pend_addr;
                    end else if (accept) begin
                        acc_mode <= mode_i;
                        if (park_now && res_valid) begin
                            state    <= ST_ISSUE;
                            iss_addr <= res_taken ? core_addr : res_seq_addr;
                        end else if (park_now) begin
                            state    <= ST_HOLD;
                            tgt_addr <= core_addr;
                        end else begin
                            state    <= ST_ISSUE;
                            iss_addr <= core_addr;
                        end
                    end
                end
                ST_HOLD: begin
                    if (res_valid) begin
                        state    <= ST_ISSUE;
                        iss_addr <= res_taken ? tgt_addr : res_seq_addr;
                    end
                end
                ST_ISSUE: state <= ST_WAIT;
                ST_WAIT: begin
                    if (mem_rvalid) begin
                        if (mode_wait(acc_mode)) begin
                            state    <= ST_DLV;
                            dlv_data <= mem_rdata;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                ST_DLV:  state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Record a sequential fetch owed by a not-taken speculative branch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_pend  <= 1'b0;
            pend_addr <= '0;
        end else if (pend_set) begin
            seq_pend  <= 1'b1;
            pend_addr <= res_seq_addr;
        end else if (pend_take) begin
            seq_pend <= 1'b0;
        end
    end

    assign mem_rd      = (state == ST_ISSUE);
    assign mem_addr    = iss_addr;
    assign core_busy   = (state != ST_IDLE) || seq_pend;
    assign core_rvalid = (state == ST_DLV) ||
                         ((state == ST_WAIT) && mem_rvalid && !mode_wait(acc_mode));
    assign core_rdata  = (state == ST_DLV) ? dlv_data : mem_rdata;

    a_r4_parked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (park_now && !res_valid) |=> !mem_rd);
    a_r5_resolved_issue: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && res_valid) |=> mem_rd &&
            mem_addr == ($past(res_taken) ? $past(tgt_addr) : $past(res_seq_addr)));
    a_r3_one_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && mem_rvalid && mode_wait(acc_mode)) |=>
            core_rvalid && core_rdata == $past(mem_rdata));
    a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !mem_rd);
    a_r10_issue_next: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !park_now) |=> mem_rd && mem_addr == $past(core_addr));
    a_r7_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> $stable(acc_mode));
    a_r8_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> core_busy);
endmodule

// File: rtl/fetch_wait_ctrl.sv
// Top of the flash fetch wait-state controller: mode register, access
// sequencer and strobe counter. Assumes a single clock and a synchronous
// active-low reset; the flash answers each strobe with one mem_rvalid.
module fetch_wait_ctrl
    import fwc_pkg::*;
#(
    parameter int AW    = 16,
    parameter int DW    = 32,
    parameter int REG_W = 32,
    parameter int CW    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [REG_W-1:0] cfg_wdata,
    output logic [REG_W-1:0] cfg_rdata,
    input  logic             core_req,
    input  logic [AW-1:0]    core_addr,
    input  logic             core_cbt,
    output logic             core_busy,
    output logic             core_rvalid,
    output logic [DW-1:0]    core_rdata,
    input  logic             res_valid,
    input  logic             res_taken,
    input  logic [AW-1:0]    res_seq_addr,
    output logic             mem_rd,
    output logic [AW-1:0]    mem_addr,
    input  logic             mem_rvalid,
    input  logic [DW-1:0]    mem_rdata,
    output logic [CW-1:0]    strobe_cnt
);
    rd_mode_e mode;

    fwc_mode_reg #(.REG_W(REG_W)) u_mode (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .rdata (cfg_rdata),
        .mode  (mode)
    );

    fwc_seq #(.AW(AW), .DW(DW)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_i       (mode),
        .core_req     (core_req),
        .core_addr    (core_addr),
        .core_cbt     (core_cbt),
        .core_busy    (core_busy),
        .core_rvalid  (core_rvalid),
        .core_rdata   (core_rdata),
        .res_valid    (res_valid),
        .res_taken    (res_taken),
        .res_seq_addr (res_seq_addr),
        .mem_rd       (mem_rd),
        .mem_addr     (mem_addr),
        .mem_rvalid   (mem_rvalid),
        .mem_rdata    (mem_rdata)
    );

    fwc_strobe_cnt #(.CW(CW)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (mem_rd),
        .count  (strobe_cnt)
    );
endmodule

// File: tb/tb_fetch_wait_ctrl.sv
// Self-checking bench: table of mode/branch vectors, then directed cases.
module tb_fetch_wait_ctrl;
    localparam int AW = 16;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [31:0]   cfg_wdata = '0;
    logic [31:0]   cfg_rdata;
    logic          core_req = 1'b0;
    logic [AW-1:0] core_addr = '0;
    logic          core_cbt = 1'b0;
    logic          core_busy, core_rvalid;
    logic [DW-1:0] core_rdata;
    logic          res_valid = 1'b0;
    logic          res_taken = 1'b0;
    logic [AW-1:0] res_seq_addr = '0;
    logic          mem_rd;
    logic [AW-1:0] mem_addr;
    logic          mem_rvalid;
    logic [DW-1:0] mem_rdata;
    logic [15:0]   strobe_cnt;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    fetch_wait_ctrl dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .core_req(core_req), .core_addr(core_addr),
        .core_cbt(core_cbt), .core_busy(core_busy), .core_rvalid(core_rvalid),
        .core_rdata(core_rdata), .res_valid(res_valid), .res_taken(res_taken),
        .res_seq_addr(res_seq_addr), .mem_rd(mem_rd), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .strobe_cnt(strobe_cnt)
    );

    function automatic logic [DW-1:0] fdata(input logic [AW-1:0] a);
        return {a ^ 16'h5A3C, a};
    endfunction

    // Flash model: answers each strobe one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_rvalid <= 1'b0;
            mem_rdata  <= '0;
        end else begin
            mem_rvalid <= mem_rd;
            mem_rdata  <= fdata(mem_addr);
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [31:0] v);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // {mode[1:0], cbt, taken, addr[15:0], seq[15:0]}
    localparam int NV = 12;
    localparam logic [35:0] VEC [NV] = '{
        {2'd0, 1'b0, 1'b0, 16'h0100, 16'h0000},
        {2'd1, 1'b0, 1'b0, 16'h0204, 16'h0000},
        {2'd2, 1'b0, 1'b0, 16'h0308, 16'h0000},
        {2'd3, 1'b0, 1'b0, 16'h040C, 16'h0000},
        {2'd0, 1'b1, 1'b0, 16'h1000, 16'h0510},
        {2'd0, 1'b1, 1'b1, 16'h1100, 16'h0514},
        {2'd1, 1'b1, 1'b0, 16'h1200, 16'h0518},
        {2'd1, 1'b1, 1'b1, 16'h1300, 16'h051C},
        {2'd2, 1'b1, 1'b0, 16'h1400, 16'h0520},
        {2'd2, 1'b1, 1'b1, 16'h1500, 16'h0524},
        {2'd3, 1'b1, 1'b0, 16'h1600, 16'h0528},
        {2'd3, 1'b1, 1'b1, 16'h1700, 16'h052C}
    };

    task automatic run_vec(input logic [35:0] v);
        logic [1:0]  m;
        logic        cbt, tk;
        logic [15:0] a, s, c0;
        int ns, nr, first_st, first_rv, hold_viol, exp_ns, exp_first_cyc;
        logic [15:0] st_addr [2];
        logic [31:0] last_data;
        logic [15:0] exp_first, exp_last;
        m = v[35:34]; cbt = v[33]; tk = v[32]; a = v[31:16]; s = v[15:0];
        ns = 0; nr = 0; first_st = 0; first_rv = 0; hold_viol = 0;
        st_addr[0] = '0; st_addr[1] = '0; last_data = '0;
        // Ones in reserved bits must be dropped (R2).
        cfg_write({30'h3FFF_FFFF, m});
        chk(cfg_rdata == {30'd0, m}, "R2", "readback", cfg_rdata, {30'd0, m});
        c0 = strobe_cnt;
        core_req = 1'b1; core_addr = a; core_cbt = cbt;
        @(negedge clk);
        core_req = 1'b0; core_cbt = 1'b0;
        for (int cyc = 1; cyc <= 12; cyc++) begin
            if (cyc > 1) @(negedge clk);
            res_valid = 1'b0;
            if (mem_rd) begin
                if (ns < 2) st_addr[ns] = mem_addr;
                ns++;
                if (ns == 1) first_st = cyc;
                if (cbt && m[1] && cyc <= 2) hold_viol = 1;
            end
            if (core_rvalid) begin
                nr++;
                last_data = core_rdata;
                if (nr == 1) first_rv = cyc;
            end
            if (cbt && cyc == 2) begin
                res_valid = 1'b1; res_taken = tk; res_seq_addr = s;
            end
        end
        exp_ns        = (cbt && !tk && !m[1]) ? 2 : 1;
        exp_first     = (cbt && m[1] && !tk) ? s : a;
        exp_last      = (exp_ns == 2) ? s : exp_first;
        exp_first_cyc = (cbt && m[1]) ? 3 : 1;
        chk(hold_viol == 0, "R4", "strobe before resolution", hold_viol, 0);
        chk(ns == exp_ns, "R6", "strobe count", ns, exp_ns);
        chk(st_addr[0] == exp_first, "R5", "first strobe address", st_addr[0], exp_first);
        chk(first_st == exp_first_cyc, cbt && m[1] ? "R5" : "R10", "strobe cycle",
            first_st, exp_first_cyc);
        if (exp_ns == 2)
            chk(st_addr[1] == s, "R6", "sequential strobe address", st_addr[1], s);
        chk(first_rv == first_st + 1 + int'(m[0]), "R3", "data latency",
            first_rv - first_st, 1 + int'(m[0]));
        chk(nr == exp_ns, "R3", "data beats", nr, exp_ns);
        chk(last_data == fdata(exp_last), "R3", "data value", last_data, fdata(exp_last));
        chk(strobe_cnt - c0 == 16'(exp_ns), "R9", "counter delta", strobe_cnt - c0, exp_ns);
        chk(core_busy == 1'b0, "R8", "idle after access", core_busy, 0);
    endtask

    initial begin
        int lat, ns;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state (R1, R9)
        chk(cfg_rdata == 32'd1, "R1", "reset mode", cfg_rdata, 1);
        chk(strobe_cnt == 16'd0, "R9", "reset count", strobe_cnt, 0);
        chk(core_busy == 1'b0 && mem_rd == 1'b0, "R8", "reset idle",
            {core_busy, mem_rd}, 0);

        for (int i = 0; i < NV; i++) run_vec(VEC[i]);

        // R2: reserved ones only, field zero
        cfg_write(32'hFFFF_FFFC);
        chk(cfg_rdata == 32'd0, "R2", "reserved write", cfg_rdata, 0);
        // R1: each encoding reads back
        cfg_write(32'd3);
        chk(cfg_rdata == 32'd3, "R1", "mode 3 readback", cfg_rdata, 3);

        // R7: mode change during a one-wait access
        cfg_write(32'd1);
        core_req = 1'b1; core_addr = 16'h2222; core_cbt = 1'b0;
        @(negedge clk);
        core_req = 1'b0;
        cfg_we = 1'b1; cfg_wdata = 32'd0;
        lat = 0;
        for (int cyc = 1; cyc <= 8; cyc++) begin
            if (cyc > 1) @(negedge clk);
            if (cyc == 2) cfg_we = 1'b0;
            if (core_rvalid && lat == 0) lat = cyc;
        end
        chk(lat == 3, "R7", "mid-access write ignored", lat, 3);
        core_req = 1'b1; core_addr = 16'h2224;
        @(negedge clk);
        core_req = 1'b0;
        lat = 0;
        for (int cyc = 1; cyc <= 8; cyc++) begin
            if (cyc > 1) @(negedge clk);
            if (core_rvalid && lat == 0) lat = cyc;
        end
        chk(lat == 2, "R7", "new mode on next access", lat, 2);

        // R8: request held high back to back in mode 0
        core_req = 1'b1; core_addr = 16'h3330;
        @(negedge clk);
        ns = 0;
        for (int cyc = 1; cyc <= 4; cyc++) begin
            if (cyc > 1) @(negedge clk);
            if (cyc == 2) chk(core_busy == 1'b1, "R8", "busy during access", core_busy, 1);
            if (mem_rd && cyc <= 3) ns++;
            if (cyc == 4) begin
                chk(mem_rd == 1'b1, "R8", "second strobe after data", mem_rd, 1);
                core_req = 1'b0;
            end
        end
        chk(ns == 1, "R8", "one outstanding access", ns, 1);
        repeat (6) @(negedge clk);
        chk(core_busy == 1'b0, "R8", "idle again", core_busy, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule